// File: doc/BRIEF.md
# Seven-Stage Pipeline Interlock Controller

This block is the hazard and stall controller of an in-order integer pipeline with seven single-cycle stages: IF1, IF2, ID, EX, MEM1, MEM2 and WB. Fetch takes two cycles and data memory access takes two cycles. The pipeline has no bypass network. The register file is written on the falling clock edge, so an instruction in ID can read a value that WB writes in the same cycle. Branches are compared by the ALU in EX, so their outcome is not known before the end of EX.

The controller keeps a small token for every instruction that has left ID. Each token carries a valid bit, a destination register, a write flag and a branch flag. Each cycle the controller compares the source registers of the instruction in ID against the writing destinations in EX, MEM1 and MEM2. On a match it freezes the PC, IF1, IF2 and ID and places a bubble into EX. Tokens already past ID keep moving, so the stall ends once the producer reaches WB.

A small state machine handles branches and has two states. In `ST_RUN` the state machine issues instructions and raises data stalls. Issuing a branch takes it from `ST_RUN` to `ST_RESOLVE`. In `ST_RESOLVE` the branch sits in EX, and the controller redirects the PC to the target or to the fall-through address. It then returns to `ST_RUN` unconditionally after that single cycle. The surrounding datapath follows one convention: when fetch is held but decode is not, ID loads a bubble. On a redirect, IF1, IF2 and ID are cleared.

Top module: `pipe7_interlock`

## Requirements
- R1: A synchronous reset clears every token and returns the state machine to `ST_RUN`. With `id_valid` low, all of `stall_fetch`, `stall_decode`, `bubble_ex` and `redirect` are 0 and `pc_sel` is 0 (sequential). A reset applied while instructions are in flight leaves no stale dependence and no pending redirect.
- R2: A consumer directly behind a register-writing producer is held for exactly 3 cycles. In each held cycle `stall_fetch`, `stall_decode` and `bubble_ex` are 1 and `pc_sel` is 1 (hold).
- R3: A consumer placed 2, 3 or 4 issue slots behind its producer is held for 2, 1 or 0 cycles respectively.
- R4: None of the following causes a stall: a destination of register 0, a producer whose write flag is clear, or a source whose enable is low.
- R5: The controller checks both source operands. A match on the second source (bits [2*AW-1:AW] of `id_src_addr`) stalls like a match on the first (bits [AW-1:0]).
- R6: In the cycle a branch issues from ID with no data hazard, `stall_fetch` is 1, `stall_decode` is 0, `bubble_ex` is 0, `redirect` is 0 and `pc_sel` is 1 (hold).
- R7: In the cycle after a branch issues (`ST_RESOLVE`), `redirect` and `bubble_ex` are 1 and both stall outputs are 0. `pc_sel` is 2 (target) when `ex_branch_taken` is 1 and 3 (fall-through) when it is 0.
- R8: `ST_RESOLVE` lasts exactly one cycle. Any instruction presented in ID during that cycle is discarded and creates no dependence for later instructions. After that cycle the outputs are idle again.
- R9: A branch that depends on an in-flight producer first stalls like any consumer, with `redirect` low. It issues only when the hazard clears, and its redirect follows one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| id_valid | input | 1 | ID stage holds an instruction |
| id_src_addr | input | NSRC*AW | Source register numbers of the ID instruction, source 0 in the low bits |
| id_src_en | input | NSRC | Per-source read enable |
| id_dst_addr | input | AW | Destination register of the ID instruction |
| id_dst_wr | input | 1 | ID instruction writes its destination |
| id_is_branch | input | 1 | ID instruction is a conditional branch |
| ex_branch_taken | input | 1 | ALU comparison result for the branch in EX |
| stall_fetch | output | 1 | Hold the PC, IF1 and IF2 |
| stall_decode | output | 1 | Hold ID |
| bubble_ex | output | 1 | Load a bubble into EX |
| redirect | output | 1 | Load the PC from `pc_sel` and clear IF1, IF2 and ID |
| pc_sel | output | 2 | Next PC: 0 sequential, 1 hold, 2 branch target, 3 fall-through |

## Verification
A token that is lost, duplicated or left valid after a bubble shows up as a wrong stall length. The error is visible in the very next dependent instruction, as early as the cycle after the fault: the consumer is held one cycle too many or too few. A state machine stuck in, or skipping, `ST_RESOLVE` shows up on `redirect` and `pc_sel` in the cycle right after a branch issues. Directed distance sweeps and branch sequences check those cycles exactly.

// File: rtl/pipe7_ilk_pkg.sv
package pipe7_ilk_pkg;

    // Next-PC choice driven to the fetch unit
    typedef enum logic [1:0] {
        PC_SEQ    = 2'b00,
        PC_HOLD   = 2'b01,
        PC_TARGET = 2'b10,
        PC_FALL   = 2'b11
    } pc_sel_e;

    // Branch control state
    typedef enum logic {
        ST_RUN     = 1'b0,
        ST_RESOLVE = 1'b1
    } ctl_state_e;

endpackage

// File: rtl/pipe7_token_pipe.sv
module pipe7_token_pipe #(
    parameter int AW    = 5,
    parameter int DEPTH = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [AW-1:0] in_dst,
    input  logic          in_wr,
    input  logic          in_br,
    output logic          stg_valid [DEPTH],
    output logic [AW-1:0] stg_dst   [DEPTH],
    output logic          stg_wr    [DEPTH],
    output logic          stg_br    [DEPTH]
);

    // Stage 0 is EX; later entries are the memory stages, WB is not kept
    // because a WB writer is readable by ID in the same cycle.
    for (genvar k = 0; k < DEPTH; k++) begin : g_stage
        if (k == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) begin
                    stg_valid[k] <= 1'b0;
                    stg_dst[k]   <= '0;
                    stg_wr[k]    <= 1'b0;
                    stg_br[k]    <= 1'b0;
                end else begin
                    stg_valid[k] <= in_valid;
                    stg_dst[k]   <= in_valid ? in_dst : '0;
                    stg_wr[k]    <= in_valid & in_wr;
                    stg_br[k]    <= in_valid & in_br;
                end
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst) begin
                    stg_valid[k] <= 1'b0;
                    stg_dst[k]   <= '0;
                    stg_wr[k]    <= 1'b0;
                    stg_br[k]    <= 1'b0;
                end else begin
                    stg_valid[k] <= stg_valid[k-1];
                    stg_dst[k]   <= stg_dst[k-1];
                    stg_wr[k]    <= stg_wr[k-1];
                    stg_br[k]    <= stg_br[k-1];
                end
            end
        end
    end

endmodule

// File: rtl/pipe7_hazard.sv
module pipe7_hazard #(
    parameter int AW    = 5,
    parameter int NSRC  = 2,
    parameter int DEPTH = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               id_valid,
    input  logic [NSRC*AW-1:0] src_addr,
    input  logic [NSRC-1:0]    src_en,
    input  logic               stg_valid [DEPTH],
    input  logic [AW-1:0]      stg_dst   [DEPTH],
    input  logic               stg_wr    [DEPTH],
    output logic               raw_hit
);

    localparam int NCMP = NSRC * DEPTH;
    localparam int RW   = $clog2(DEPTH + 2) + 1;

    logic [NCMP-1:0] hit;

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        for (genvar k = 0; k < DEPTH; k++) begin : g_stg
            assign hit[s*DEPTH + k] = id_valid && src_en[s] && stg_valid[k] &&
                                      stg_wr[k] && (stg_dst[k] != '0) &&
                                      (stg_dst[k] == src_addr[s*AW +: AW]);
        end
    end

    assign raw_hit = |hit;

    // Checker: a held instruction never waits longer than the producer
    // needs to walk from EX to WB.
    logic [RW-1:0] run_len;
    always_ff @(posedge clk) begin
        if (rst)
            run_len <= '0;
        else if (raw_hit)
            run_len <= (run_len == {RW{1'b1}}) ? run_len : run_len + 1'b1;
        else
            run_len <= '0;
    end

    p_stall_run_r2: assert property (@(posedge clk) disable iff (rst)
        run_len <= RW'(DEPTH))
        else $error("data stall longer than %0d cycles", DEPTH);

endmodule

// File: rtl/pipe7_branch_fsm.sv
module pipe7_branch_fsm
    import pipe7_ilk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       id_valid,
    input  logic       id_is_branch,
    input  logic       raw_hit,
    input  logic       ex_taken,
    output logic       issue,
    output logic       stall_fetch,
    output logic       stall_decode,
    output logic       bubble_ex,
    output logic       redirect,
    output pc_sel_e    pc_sel,
    output ctl_state_e state
);

    ctl_state_e state_nxt;

    // State register
    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_RUN;
        else
            state <= state_nxt;
    end

    // Transitions: branch issue moves RUN to RESOLVE, RESOLVE always returns
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_RUN:
                if (id_valid && !raw_hit && id_is_branch)
                    state_nxt = ST_RESOLVE;
            ST_RESOLVE:
                state_nxt = ST_RUN;
            default:
                state_nxt = ST_RUN;
        endcase
    end

    // Outputs
    always_comb begin
        issue        = 1'b0;
        stall_fetch  = 1'b0;
        stall_decode = 1'b0;
        bubble_ex    = 1'b0;
        redirect     = 1'b0;
        pc_sel       = PC_SEQ;
        unique case (state)
            ST_RUN: begin
                if (id_valid && raw_hit) begin
                    stall_fetch  = 1'b1;
                    stall_decode = 1'b1;
                    bubble_ex    = 1'b1;
                    pc_sel       = PC_HOLD;
                end else if (id_valid && id_is_branch) begin
                    issue       = 1'b1;
                    stall_fetch = 1'b1;
                    pc_sel      = PC_HOLD;
                end else if (id_valid) begin
                    issue = 1'b1;
                end
            end
            ST_RESOLVE: begin
                redirect  = 1'b1;
                bubble_ex = 1'b1;
                pc_sel    = ex_taken ? PC_TARGET : PC_FALL;
            end
            default: begin
                pc_sel = PC_SEQ;
            end
        endcase
    end

    p_redirect_single_r8: assert property (@(posedge clk) disable iff (rst)
        redirect |=> !redirect)
        else $error("redirect held for two cycles");

    p_resolve_after_branch_r6: assert property (@(posedge clk) disable iff (rst)
        (state_nxt == ST_RESOLVE) |=> (state == ST_RESOLVE) && $past(issue && id_is_branch))
        else $error("resolve entered without a branch issue");

endmodule

// File: rtl/pipe7_interlock.sv
module pipe7_interlock
    import pipe7_ilk_pkg::*;
#(
    parameter int AW         = 5,
    parameter int NSRC       = 2,
    parameter int MEM_CYCLES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               id_valid,
    input  logic [NSRC*AW-1:0] id_src_addr,
    input  logic [NSRC-1:0]    id_src_en,
    input  logic [AW-1:0]      id_dst_addr,
    input  logic               id_dst_wr,
    input  logic               id_is_branch,
    input  logic               ex_branch_taken,
    output logic               stall_fetch,
    output logic               stall_decode,
    output logic               bubble_ex,
    output logic               redirect,
    output logic [1:0]         pc_sel
);

    // Stages between ID and WB: EX plus the memory cycles
    localparam int DEPTH = 1 + MEM_CYCLES;

    logic          stg_valid [DEPTH];
    logic [AW-1:0] stg_dst   [DEPTH];
    logic          stg_wr    [DEPTH];
    logic          stg_br    [DEPTH];
    logic          raw_hit;
    logic          issue;
    pc_sel_e       pc_sel_w;
    ctl_state_e    state;

    pipe7_token_pipe #(.AW(AW), .DEPTH(DEPTH)) u_tokens (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (issue),
        .in_dst    (id_dst_addr),
        .in_wr     (id_dst_wr),
        .in_br     (id_is_branch),
        .stg_valid (stg_valid),
        .stg_dst   (stg_dst),
        .stg_wr    (stg_wr),
        .stg_br    (stg_br)
    );

    pipe7_hazard #(.AW(AW), .NSRC(NSRC), .DEPTH(DEPTH)) u_hazard (
        .clk       (clk),
        .rst       (rst),
        .id_valid  (id_valid),
        .src_addr  (id_src_addr),
        .src_en    (id_src_en),
        .stg_valid (stg_valid),
        .stg_dst   (stg_dst),
        .stg_wr    (stg_wr),
        .raw_hit   (raw_hit)
    );

    pipe7_branch_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .id_valid     (id_valid),
        .id_is_branch (id_is_branch),
        .raw_hit      (raw_hit),
        .ex_taken     (ex_branch_taken),
        .issue        (issue),
        .stall_fetch  (stall_fetch),
        .stall_decode (stall_decode),
        .bubble_ex    (bubble_ex),
        .redirect     (redirect),
        .pc_sel       (pc_sel_w),
        .state        (state)
    );

    assign pc_sel = pc_sel_w;

    // The branch being resolved must be the token sitting in EX
    p_resolve_branch_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RESOLVE) |-> (stg_valid[0] && stg_br[0]))
        else $error("resolve state without a branch token in EX");

    // A requested bubble leaves EX empty on the next cycle
    p_bubble_empty_r2: assert property (@(posedge clk) disable iff (rst)
        bubble_ex |=> !stg_valid[0])
        else $error("EX not empty after bubble");

endmodule

// File: tb/pipe7_interlock_tb_top.sv
module pipe7_interlock_tb_top;

    localparam int AW   = 5;
    localparam int NSRC = 2;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               id_valid = 1'b0;
    logic [NSRC*AW-1:0] id_src_addr = '0;
    logic [NSRC-1:0]    id_src_en = '0;
    logic [AW-1:0]      id_dst_addr = '0;
    logic               id_dst_wr = 1'b0;
    logic               id_is_branch = 1'b0;
    logic               ex_branch_taken = 1'b0;
    logic               stall_fetch, stall_decode, bubble_ex, redirect;
    logic [1:0]         pc_sel;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    pipe7_interlock dut_i (
        .clk             (clk),
        .rst             (rst),
        .id_valid        (id_valid),
        .id_src_addr     (id_src_addr),
        .id_src_en       (id_src_en),
        .id_dst_addr     (id_dst_addr),
        .id_dst_wr       (id_dst_wr),
        .id_is_branch    (id_is_branch),
        .ex_branch_taken (ex_branch_taken),
        .stall_fetch     (stall_fetch),
        .stall_decode    (stall_decode),
        .bubble_ex       (bubble_ex),
        .redirect        (redirect),
        .pc_sel          (pc_sel)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Present one ID slot at the falling edge, outputs sampled 1 ns later
    task automatic put(input logic v, input int s0, input logic e0,
                       input int s1, input logic e1, input int rd,
                       input logic wr, input logic br, input logic tk);
        @(negedge clk);
        id_valid        = v;
        id_src_addr     = {AW'(s1), AW'(s0)};
        id_src_en       = {e1, e0};
        id_dst_addr     = AW'(rd);
        id_dst_wr       = wr;
        id_is_branch    = br;
        ex_branch_taken = tk;
        #1;
    endtask

    // Hold an instruction in ID until released; returns held cycles
    task automatic run_inst(input int s0, input logic e0, input int s1,
                            input logic e1, input int rd, input logic wr,
                            input logic br, output int held);
        held = 0;
        put(1'b1, s0, e0, s1, e1, rd, wr, br, 1'b0);
        while (stall_decode && held < 20) begin
            held++;
            @(negedge clk);
            #1;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) put(1'b0, 0, 1'b0, 0, 1'b0, 0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic filler();
        int h;
        run_inst(0, 1'b0, 0, 1'b0, 0, 1'b0, 1'b0, h);
    endtask

    task automatic t_reset();
        idle(1);
        chk("R1 stall_fetch", stall_fetch, 0);
        chk("R1 stall_decode", stall_decode, 0);
        chk("R1 bubble_ex", bubble_ex, 0);
        chk("R1 redirect", redirect, 0);
        chk("R1 pc_sel", pc_sel, 0);
    endtask

    task automatic t_adjacent();
        int h;
        run_inst(1, 1'b1, 2, 1'b1, 5, 1'b1, 1'b0, h);
        put(1'b1, 5, 1'b1, 3, 1'b1, 6, 1'b1, 1'b0, 1'b0);
        chk("R2 stall_fetch", stall_fetch, 1);
        chk("R2 bubble_ex", bubble_ex, 1);
        chk("R2 pc_sel hold", pc_sel, 1);
        h = 1;
        while (stall_decode && h < 20) begin
            h++;
            @(negedge clk);
            #1;
        end
        chk("R2 adjacent stall count", h - 1, 3);
        idle(4);
    endtask

    task automatic t_distance();
        int h;
        for (int gap = 1; gap <= 3; gap++) begin
            run_inst(0, 1'b0, 0, 1'b0, 7, 1'b1, 1'b0, h);
            for (int f = 0; f < gap; f++) filler();
            run_inst(1, 1'b1, 7, 1'b1, 0, 1'b0, 1'b0, h);
            chk($sformatf("R3 R5 distance %0d stall count", gap + 1), h, 3 - gap);
            idle(4);
        end
    endtask

    task automatic t_no_match();
        int h;
        run_inst(0, 1'b0, 0, 1'b0, 0, 1'b1, 1'b0, h);
        run_inst(0, 1'b1, 0, 1'b1, 4, 1'b1, 1'b0, h);
        chk("R4 register 0 destination", h, 0);
        idle(4);
        run_inst(0, 1'b0, 0, 1'b0, 8, 1'b0, 1'b0, h);
        run_inst(8, 1'b1, 8, 1'b1, 0, 1'b0, 1'b0, h);
        chk("R4 write flag clear", h, 0);
        idle(4);
        run_inst(0, 1'b0, 0, 1'b0, 9, 1'b1, 1'b0, h);
        run_inst(9, 1'b0, 9, 1'b0, 0, 1'b0, 1'b0, h);
        chk("R4 source disabled", h, 0);
        idle(4);
        run_inst(0, 1'b0, 0, 1'b0, 10, 1'b1, 1'b0, h);
        run_inst(3, 1'b1, 10, 1'b1, 0, 1'b0, 1'b0, h);
        chk("R5 second source adjacent", h, 3);
        idle(4);
    endtask

    task automatic t_branch(input logic taken);
        int h;
        run_inst(0, 1'b0, 0, 1'b0, 0, 1'b0, 1'b1, h);
        chk("R6 branch held", h, 0);
        chk("R6 stall_fetch", stall_fetch, 1);
        chk("R6 stall_decode", stall_decode, 0);
        chk("R6 bubble_ex", bubble_ex, 0);
        chk("R6 redirect", redirect, 0);
        chk("R6 pc_sel hold", pc_sel, 1);
        // Junk in ID during resolve: writes r11
        put(1'b1, 0, 1'b0, 0, 1'b0, 11, 1'b1, 1'b0, taken);
        chk("R7 redirect", redirect, 1);
        chk("R7 pc_sel", pc_sel, taken ? 2 : 3);
        chk("R7 stall_fetch", stall_fetch, 0);
        chk("R7 stall_decode", stall_decode, 0);
        chk("R7 bubble_ex", bubble_ex, 1);
        run_inst(11, 1'b1, 0, 1'b0, 0, 1'b0, 1'b0, h);
        chk("R8 discarded slot causes no stall", h, 0);
        chk("R8 redirect back low", redirect, 0);
        chk("R8 pc_sel sequential", pc_sel, 0);
        idle(4);
    endtask

    task automatic t_branch_hazard();
        int h;
        int redir_seen;
        run_inst(0, 1'b0, 0, 1'b0, 12, 1'b1, 1'b0, h);
        put(1'b1, 12, 1'b1, 0, 1'b0, 0, 1'b0, 1'b1, 1'b0);
        h = 0;
        redir_seen = 0;
        while (stall_decode && h < 20) begin
            h++;
            if (redirect) redir_seen++;
            @(negedge clk);
            #1;
        end
        chk("R9 branch stall count", h, 3);
        chk("R9 no redirect while held", redir_seen, 0);
        put(1'b0, 0, 1'b0, 0, 1'b0, 0, 1'b0, 1'b0, 1'b1);
        chk("R9 redirect after issue", redirect, 1);
        chk("R9 target selected", pc_sel, 2);
        idle(4);
    endtask

    task automatic t_reset_mid();
        int h;
        run_inst(0, 1'b0, 0, 1'b0, 14, 1'b1, 1'b1, h);
        put(1'b0, 0, 1'b0, 0, 1'b0, 0, 1'b0, 1'b0, 1'b0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 no pending redirect", redirect, 0);
        run_inst(14, 1'b1, 0, 1'b0, 0, 1'b0, 1'b0, h);
        chk("R1 reset clears tokens", h, 0);
        idle(4);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_adjacent();
        t_distance();
        t_no_match();
        t_branch(1'b1);
        t_branch(1'b0);
        t_branch_hazard();
        t_reset_mid();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(10 * 20000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule